// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Event Timer

This block is a down-counting event timer. It advances on a one-cycle enable pulse, `tick`, that arrives once per microsecond. Software controls it through two word registers on a small write/read bus. The trigger register holds three things:

- an enable bit;
- an auto-reload (periodic) bit;
- a 29-bit count.

Software loads N-1 into the count to get an event after N ticks. When the countdown passes zero, the timer raises a level-high interrupt. In periodic mode the timer then reloads the programmed count and keeps running. In one-shot mode it stops and drops its enable bit. The interrupt stays asserted until software writes a one into the acknowledge bit of the second register.

The control core is a two-state machine with the states `TS_IDLE` and `TS_RUN`. Its transitions are:

- **ARM**: a trigger write with the enable bit set. It moves from any state to `TS_RUN`.
- **STOP**: a trigger write with the enable bit clear. It moves from any state to `TS_IDLE`.
- **COUNT**: a tick in `TS_RUN` with a nonzero count. The state stays `TS_RUN` and the count falls by one.
- **RELOAD**: a tick in `TS_RUN` at zero count in periodic mode. The state stays `TS_RUN`, the stored count is reloaded and an expiry is signalled.
- **FINISH**: a tick in `TS_RUN` at zero count in one-shot mode. The state moves to `TS_IDLE` and an expiry is signalled.

In `TS_IDLE`, with no trigger write, the state and the count hold.

A separate interrupt latch records each expiry. The bus decoder turns writes into load and acknowledge strobes. The same decoder multiplexes read data.

Top module: `evt_timer`

## Requirements
- R1: After reset the timer is in `TS_IDLE`. The interrupt output is low, and both registers read as zero.
- R2: A write to byte offset 0x0 (the trigger register) loads three fields and restarts the countdown from the new count:
  - bit 31 is the enable bit and selects ARM or STOP;
  - bit 30 is the periodic bit;
  - bits 28:0 are the count, which is also stored as the reload value.

  Bit 29 is ignored. A trigger write in the same cycle as a tick takes precedence, and that tick is not counted.
- R3: A read of offset 0x0 returns the enable state in bit 31, the periodic bit in bit 30, zero in bit 29 and the current remaining count in bits 28:0.
- R4: Each tick in `TS_RUN` with a nonzero count lowers the count by one. Ticks in `TS_IDLE` leave the count unchanged.
- R5: A tick in `TS_RUN` at zero count is an expiry. The interrupt output is high from the next clock edge, so a loaded count of N-1 gives the interrupt on the Nth tick.
- R6: On a one-shot expiry the enable bit clears and the count stays at zero. Later ticks cause no further expiry.
- R7: On a periodic expiry the count reloads to the last written count and the enable bit stays set. The countdown continues, so further expiries follow.
- R8: A write to offset 0x4 with bit 30 set acknowledges the interrupt, and the output is low from the next edge. Bit 30 clear in that write has no effect. An expiry in the same cycle as an acknowledge keeps the interrupt high.
- R9: A read of offset 0x4 returns the pending interrupt in bit 30 and zero elsewhere.
- R10: The interrupt is a level held until it is acknowledged. Trigger writes, including a write of zero that stops the timer, do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable, one per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level-high interrupt |

## Verification
The countdown is tried with several patterns:

- A one-shot load of 3 shows that the interrupt comes on the fourth tick and then stops the timer.
- A periodic load of 1 shows reload against halt.
- A load of zero in periodic mode makes every tick an expiry.
- The all-ones trigger word checks the widest count and that bit 29 is dropped.

Collision patterns put a tick in the same cycle as a trigger write and as an acknowledge. These tell the two precedence rules apart.

Ticks are also given while the timer is stopped. Acknowledge writes with bit 30 clear are made as well. Both show, through the read-back and the interrupt pin, that such inputs leave the state alone.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_RUN  = 1'b1
    } tmr_state_e;

    localparam int TRIG_OFS = 0;
    localparam int ACK_OFS  = 4;
    localparam int EN_POS   = 31;
    localparam int PER_POS  = 30;
    localparam int ACK_POS  = 30;

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              run_en,
    input  logic              periodic,
    input  logic [CNT_W-1:0]  count,
    input  logic              pend,
    output logic              trig_wr,
    output logic              trig_en,
    output logic              trig_per,
    output logic [CNT_W-1:0]  trig_cnt,
    output logic              ack_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

    logic hit_trig;
    logic hit_ack;

    assign hit_trig = (bus_addr == TRIG_A);
    assign hit_ack  = (bus_addr == ACK_A);

    assign trig_wr  = bus_wr && hit_trig;
    assign trig_en  = bus_wdata[EN_POS];
    assign trig_per = bus_wdata[PER_POS];
    assign trig_cnt = bus_wdata[CNT_W-1:0];
    assign ack_wr   = bus_wr && hit_ack && bus_wdata[ACK_POS];

    always_comb begin
        bus_rdata = '0;
        if (hit_trig) begin
            bus_rdata[EN_POS]    = run_en;
            bus_rdata[PER_POS]   = periodic;
            bus_rdata[CNT_W-1:0] = count;
        end else if (hit_ack) begin
            bus_rdata[ACK_POS] = pend;
        end
    end

endmodule

// File: rtl/tmr_down_fsm.sv
module tmr_down_fsm
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             load_en,
    input  logic             load_per,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             run_en,
    output logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rel_q, rel_d;
    logic             per_q, per_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
            rel_q   <= '0;
            per_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= rel_d;
            per_q   <= per_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rel_d   = rel_q;
        per_d   = per_q;
        expire  = 1'b0;
        if (load) begin
            // ARM or STOP: a trigger write overrides any tick
            cnt_d   = load_cnt;
            rel_d   = load_cnt;
            per_d   = load_per;
            state_d = load_en ? TS_RUN : TS_IDLE;
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    state_d = TS_IDLE;
                end
                TS_RUN: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            expire = 1'b1;
                            if (per_q) begin
                                cnt_d = rel_q;        // RELOAD
                            end else begin
                                state_d = TS_IDLE;    // FINISH
                            end
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;  // COUNT
                        end
                    end
                end
                default: state_d = TS_IDLE;
            endcase
        end
    end

    assign run_en   = (state_q == TS_RUN);
    assign periodic = per_q;
    assign count    = cnt_q;
    assign reload   = rel_q;

endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    output logic pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             trig_wr;
    logic             trig_en;
    logic             trig_per;
    logic [CNT_W-1:0] trig_cnt;
    logic             ack_wr;
    logic             run_en;
    logic             periodic;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic             expire;
    logic             pend;

    tmr_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .run_en    (run_en),
        .periodic  (periodic),
        .count     (count),
        .pend      (pend),
        .trig_wr   (trig_wr),
        .trig_en   (trig_en),
        .trig_per  (trig_per),
        .trig_cnt  (trig_cnt),
        .ack_wr    (ack_wr),
        .bus_rdata (bus_rdata)
    );

    tmr_down_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (trig_wr),
        .load_en  (trig_en),
        .load_per (trig_per),
        .load_cnt (trig_cnt),
        .run_en   (run_en),
        .periodic (periodic),
        .count    (count),
        .reload   (reload),
        .expire   (expire)
    );

    tmr_irq_latch u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .ack    (ack_wr),
        .pend   (pend)
    );

    assign irq = pend;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             trig_wr,
    input logic             ack_wr,
    input logic             expire,
    input logic             run_en,
    input logic             periodic,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R5

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !expire) |=> !irq); // R8

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq); // R10

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (!run_en && count == '0)); // R6

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (run_en && count == $past(reload))); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && count != '0 && !trig_wr) |=> (count == $past(count) - ONE)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !trig_wr) |=> $stable(count)); // R4

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .trig_wr  (trig_wr),
    .ack_wr   (ack_wr),
    .expire   (expire),
    .run_en   (run_en),
    .periodic (periodic),
    .count    (count),
    .reload   (reload),
    .irq      (irq)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit samp = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    evt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (samp && q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = q.pop_front();
            act = e.is_irq ? {31'd0, irq} : bus_rdata;
            total++;
            if (act !== e.val) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
            end
        end
    end

    // one active cycle; called at posedge+1, returns at posedge+1
    task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
        @(posedge clk); #1;
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b1);
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.is_irq = 1'b0; e.val = v; e.tag = tag;
        bus_addr = a;
        q.push_back(e);
        samp = 1'b1;
        @(posedge clk); #1;
        samp = 1'b0;
    endtask

    task automatic exp_irq(input bit v, input string tag);
        exp_t e;
        e.is_irq = 1'b1; e.val = {31'd0, v}; e.tag = tag;
        q.push_back(e);
        samp = 1'b1;
        @(posedge clk); #1;
        samp = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        exp_rd(3'd0, 32'h0000_0000, "R1 trigger after reset");
        exp_rd(3'd4, 32'h0000_0000, "R1 status after reset");
        exp_irq(1'b0, "R1 irq after reset");

        // one-shot, count 3: interrupt on fourth tick
        wr(3'd0, 32'h8000_0003);
        exp_rd(3'd0, 32'h8000_0003, "R3 readback after arm");
        ticks(3);
        exp_rd(3'd0, 32'h8000_0000, "R4 count after 3 ticks");
        exp_irq(1'b0, "R5 no irq before Nth tick");
        ticks(1);
        exp_irq(1'b1, "R5 irq on Nth tick");
        exp_rd(3'd0, 32'h0000_0000, "R6 enable cleared after one-shot");
        exp_rd(3'd4, 32'h4000_0000, "R9 pending in status");
        ticks(2);
        exp_rd(3'd0, 32'h0000_0000, "R6 stopped after one-shot");
        exp_irq(1'b1, "R10 irq held");
        wr(3'd4, 32'h4000_0000);
        exp_irq(1'b0, "R8 ack drops irq");
        exp_rd(3'd4, 32'h0000_0000, "R9 status cleared");

        // periodic, count 1
        wr(3'd0, 32'hC000_0001);
        ticks(1);
        exp_rd(3'd0, 32'hC000_0000, "R4 periodic count");
        ticks(1);
        exp_irq(1'b1, "R7 periodic expiry");
        exp_rd(3'd0, 32'hC000_0001, "R7 reload");
        wr(3'd4, 32'hBFFF_FFFF);
        exp_irq(1'b1, "R8 ack with bit30 clear ignored");
        wr(3'd4, 32'h4000_0000);
        exp_irq(1'b0, "R8 ack");
        ticks(2);
        exp_irq(1'b1, "R7 second periodic expiry");

        // stop: irq remains until ack
        wr(3'd0, 32'h0000_0000);
        exp_rd(3'd0, 32'h0000_0000, "R2 write zero stops");
        exp_irq(1'b1, "R10 trigger write keeps irq");
        wr(3'd4, 32'h4000_0000);
        ticks(3);
        exp_irq(1'b0, "R6 stopped no expiry");

        // disabled load: ticks do nothing
        wr(3'd0, 32'h0000_0007);
        exp_rd(3'd0, 32'h0000_0007, "R2 disabled load");
        ticks(2);
        exp_rd(3'd0, 32'h0000_0007, "R4 idle ticks ignored");

        // periodic zero: each tick expires; collision with ack
        wr(3'd0, 32'hC000_0000);
        ticks(1);
        exp_irq(1'b1, "R5 zero count expiry");
        exp_rd(3'd0, 32'hC000_0000, "R7 zero reload");
        step(1'b1, 3'd4, 32'h4000_0000, 1'b1);
        exp_irq(1'b1, "R8 expiry beats ack");
        wr(3'd4, 32'h4000_0000);
        exp_irq(1'b0, "R8 plain ack");

        // restart and write-over-tick precedence
        wr(3'd0, 32'h8000_0005);
        ticks(2);
        exp_rd(3'd0, 32'h8000_0003, "R4 count after 2 ticks");
        step(1'b1, 3'd0, 32'h8000_0002, 1'b1);
        exp_rd(3'd0, 32'h8000_0002, "R2 write beats tick");
        ticks(2);
        exp_irq(1'b0, "R5 no early irq after restart");
        ticks(1);
        exp_irq(1'b1, "R5 irq after restart");
        wr(3'd4, 32'h4000_0000);

        // widest count, bit 29 dropped
        wr(3'd0, 32'hFFFF_FFFF);
        exp_rd(3'd0, 32'hDFFF_FFFF, "R2 max count bit29 ignored");
        ticks(1);
        exp_rd(3'd0, 32'hDFFF_FFFE, "R4 max count decrement");
        exp_irq(1'b0, "R8 irq low after ack");

        @(posedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule